// File: doc/BRIEF.md
# Rise/Fall Point PWM Channel

This block generates one pulse-width-modulated output whose waveform is set by two compare points inside an 8-bit period. The system clock first passes through a power-of-two divider and then a linear divider. Each prescaled tick advances a period counter that wraps from the programmed period value back to zero. The output goes high when the counter reaches the rising point and goes low when it reaches the falling point. When the two points are equal the output stays high for the whole period.

Software programs the channel through two write-only words. The control word holds the dividers and the mode bits. The duty word holds the period and the two compare points. The output stage applies polarity inversion, a pin enable that forces the pin low, and an open-drain mode that only ever pulls the pin low. A clock enable stops the dividers and the counter, which freezes the output at its current level. Duty-word writes normally go to a shadow copy that is loaded at the counter wrap, so no period mixes old and new settings. A mode bit lets writes take effect at once instead.

Top module: `pwm_rf_channel`

Control word layout: bits [7:0] linear divider field L (divide by L+1), bits [11:8] exponent field H (divide by 2^H), bit 12 pin enable, bit 13 open-drain mode, bit 14 invert, bit 15 clock enable, bit 16 immediate-update mode. Duty word layout: bits [7:0] falling point, bits [15:8] rising point, bits [23:16] period value P.

## Requirements
- R1: After reset, every field is 0, pwm_o is 0 and pwm_oe is 1, so the pin is actively held low.
- R2: With the clock enabled, the output repeats every 2^H x (L+1) x (P+1) system clock cycles.
- R3: With distinct rising point r and falling point f, both no greater than P, the output is high for 2^H x (L+1) x ((f - r) mod (P+1)) cycles per period, including the case r > f where the high phase spans the wrap.
- R4: When the rising point equals the falling point, the output stays high without interruption.
- R5: With pin enable (bit 12) at 0 and open-drain mode off, pwm_o stays 0 and pwm_oe stays 1 whatever the internal level.
- R6: With clock enable (bit 15) at 0, the output holds its level, and setting the bit again resumes the same period length.
- R7: Setting invert (bit 14) flips pwm_o within two clock cycles, and the period length does not change.
- R8: In open-drain mode (bit 13 set), pwm_o is always 0 and pwm_oe is 1 exactly when the enabled, polarity-adjusted level is low.
- R9: With immediate-update mode (bit 16) at 0, a duty write during a period leaves that period unchanged and applies from the period after the next wrap.
- R10: With immediate-update mode at 1, a duty write changes the waveform starting with the next prescaled tick, within the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 17 | Control word value |
| duty_we | input | 1 | Write strobe for the duty word |
| duty_wdata | input | 24 | Duty word value |
| pwm_o | output | 1 | Registered pin data |
| pwm_oe | output | 1 | Registered pin drive enable, 1 = pin driven |

## Verification
A corrupted divider or period counter appears at the pin as a wrong spacing between rising edges within one period, so every measurement compares full edge-to-edge intervals against the product formula. A wrong level register or compare decision shows up as a wrong high-phase length in the first complete period after configuration. A shadow register that loads at the wrong moment is caught inside the very period in which the write lands, because the fall then moves too early or too late. Output-stage faults show up within two cycles of a control write, which is when the gating and inversion checks sample.

// File: rtl/pwm_rf_pkg.sv
package pwm_rf_pkg;
  // Default field widths shared by the channel and its bench.
  parameter int DEF_DIVH_W = 4;
  parameter int DEF_DIVL_W = 8;
  parameter int DEF_CNT_W  = 8;

  // Mode bits of the control word, above the two divider fields.
  typedef struct packed {
    logic imm_upd;   // duty writes bypass the shadow copy
    logic clk_en;    // run dividers and counter
    logic inv;       // invert output polarity
    logic od_en;     // drive low only, release when high
    logic pin_en;    // connect the level to the pin
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/pwm_rf_regs.sv
module pwm_rf_regs
  import pwm_rf_pkg::*;
#(
  parameter int DIVH_W = DEF_DIVH_W,
  parameter int DIVL_W = DEF_DIVL_W,
  parameter int CNT_W  = DEF_CNT_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ctrl_we,
  input  logic [DIVL_W+DIVH_W+MODE_W-1:0] ctrl_wdata,
  input  logic                        duty_we,
  input  logic [3*CNT_W-1:0]          duty_wdata,
  input  logic                        wrap,
  output logic [DIVH_W-1:0]           div_h,
  output logic [DIVL_W-1:0]           div_l,
  output mode_t                       mode,
  output logic [3*CNT_W-1:0]          act_q,
  output logic [3*CNT_W-1:0]          act_d
);
  localparam int CTRL_W = DIVL_W + DIVH_W + MODE_W;
  localparam int DUTY_W = 3 * CNT_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DUTY_W-1:0] shadow_q;

  assign div_l = ctrl_q[DIVL_W-1:0];
  assign div_h = ctrl_q[DIVL_W +: DIVH_W];
  assign mode  = mode_t'(ctrl_q[CTRL_W-1 -: MODE_W]);

  // Next value of the active duty word: immediate writes win, otherwise
  // the shadow copy is taken over at the end of a period.
  always_comb begin
    act_d = act_q;
    if (mode.imm_upd) begin
      if (duty_we) act_d = duty_wdata;
    end else if (wrap) begin
      act_d = shadow_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      if (duty_we) shadow_q <= duty_wdata;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/pwm_rf_prescaler.sv
module pwm_rf_prescaler
  import pwm_rf_pkg::*;
#(
  parameter int DIVH_W = DEF_DIVH_W,
  parameter int DIVL_W = DEF_DIVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIVH_W-1:0] div_h,
  input  logic [DIVL_W-1:0] div_l,
  output logic              tick
);
  // Largest exponent selects a divide by 2^(2^DIVH_W - 1).
  localparam int P1_W = (1 << DIVH_W) - 1;

  logic [P1_W-1:0]   p1_q;
  logic [P1_W-1:0]   mask;
  logic              t1;
  logic [DIVL_W-1:0] p2_q;
  logic              p2_end;

  // Low div_h bits of the free counter all set marks one stage-1 tick.
  assign mask   = ~({P1_W{1'b1}} << div_h);
  assign t1     = &(p1_q | ~mask);
  assign p2_end = (p2_q >= div_l);
  assign tick   = en & t1 & p2_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_q <= '0;
      p2_q <= '0;
    end else if (en) begin
      p1_q <= p1_q + 1'b1;
      if (t1) begin
        if (p2_end) p2_q <= '0;
        else        p2_q <= p2_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_rf_counter.sv
module pwm_rf_counter
  import pwm_rf_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] rise_n,
  input  logic [CNT_W-1:0] fall_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             level_q
);
  logic [CNT_W-1:0] cnt_n;
  logic             lvl_n;

  // High from the rising point up to (not including) the falling point,
  // across the wrap when rise > fall; equal points mean always high.
  function automatic logic in_high(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] r,
                                   input logic [CNT_W-1:0] f);
    if (r == f)     return 1'b1;
    else if (r < f) return (c >= r) && (c < f);
    else            return (c >= r) || (c < f);
  endfunction

  // >= keeps the counter bounded if the period shrinks mid-count.
  assign wrap  = tick && (cnt_q >= period);
  assign cnt_n = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
  assign lvl_n = in_high(cnt_n, rise_n, fall_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= cnt_n;
      level_q <= lvl_n;
    end
  end
endmodule

// File: rtl/pwm_rf_outstage.sv
module pwm_rf_outstage
  import pwm_rf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  level,
  input  mode_t mode,
  output logic  pwm_o,
  output logic  pwm_oe
);
  logic drv;

  assign drv = mode.pin_en & (level ^ mode.inv);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o  <= 1'b0;
      pwm_oe <= 1'b1;
    end else if (mode.od_en) begin
      pwm_o  <= 1'b0;
      pwm_oe <= ~drv;
    end else begin
      pwm_o  <= drv;
      pwm_oe <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_rf_channel.sv
module pwm_rf_channel
  import pwm_rf_pkg::*;
#(
  parameter int DIVH_W = DEF_DIVH_W,
  parameter int DIVL_W = DEF_DIVL_W,
  parameter int CNT_W  = DEF_CNT_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ctrl_we,
  input  logic [DIVL_W+DIVH_W+MODE_W-1:0] ctrl_wdata,
  input  logic                            duty_we,
  input  logic [3*CNT_W-1:0]              duty_wdata,
  output logic                            pwm_o,
  output logic                            pwm_oe
);
  localparam int DUTY_W = 3 * CNT_W;

  logic [DIVH_W-1:0] div_h;
  logic [DIVL_W-1:0] div_l;
  mode_t             mode;
  logic [DUTY_W-1:0] act_q;
  logic [DUTY_W-1:0] act_d;
  logic              tick;
  logic              wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic              level_q;

  pwm_rf_regs #(.DIVH_W(DIVH_W), .DIVL_W(DIVL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .wrap(wrap),
    .div_h(div_h), .div_l(div_l), .mode(mode),
    .act_q(act_q), .act_d(act_d)
  );

  pwm_rf_prescaler #(.DIVH_W(DIVH_W), .DIVL_W(DIVL_W)) u_pre (
    .clk(clk), .rst(rst), .en(mode.clk_en),
    .div_h(div_h), .div_l(div_l), .tick(tick)
  );

  pwm_rf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .period(act_q[2*CNT_W +: CNT_W]),
    .rise_n(act_d[CNT_W +: CNT_W]),
    .fall_n(act_d[0 +: CNT_W]),
    .cnt_q(cnt_q), .wrap(wrap), .level_q(level_q)
  );

  pwm_rf_outstage u_out (
    .clk(clk), .rst(rst), .level(level_q), .mode(mode),
    .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );
endmodule

// File: rtl/pwm_rf_checker.sv
module pwm_rf_checker
  import pwm_rf_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input logic               clk,
  input logic               rst,
  input mode_t              mode,
  input logic               tick,
  input logic               wrap,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [3*CNT_W-1:0] act_q,
  input logic               pwm_o,
  input logic               pwm_oe
);
  // R5: a disconnected pin in push-pull mode is driven low.
  a_r5_pin_forced_low: assert property (@(posedge clk) disable iff (rst)
    (!mode.pin_en && !mode.od_en) |=> (!pwm_o && pwm_oe));

  // R8: open-drain mode never drives the pin high.
  a_r8_od_no_high: assert property (@(posedge clk) disable iff (rst)
    mode.od_en |=> !pwm_o);

  // R6: a gated clock freezes the period counter.
  a_r6_gate_freezes: assert property (@(posedge clk) disable iff (rst)
    !mode.clk_en |=> $stable(cnt_q));

  // R2: reaching the period value on a tick returns the counter to zero.
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == act_q[2*CNT_W +: CNT_W]) |=> (cnt_q == '0));

  // R9: in shadowed mode the active settings move only at a wrap.
  a_r9_shadow_holds: assert property (@(posedge clk) disable iff (rst)
    (!mode.imm_upd && !wrap) |=> $stable(act_q));
endmodule

bind pwm_rf_channel pwm_rf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .tick(tick), .wrap(wrap),
  .cnt_q(cnt_q), .act_q(act_q), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
);

// File: tb/pwm_rf_channel_test.sv
module pwm_rf_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [16:0] ctrl_wdata = '0;
  logic        duty_we = 1'b0;
  logic [23:0] duty_wdata = '0;
  logic        pwm_o;
  logic        pwm_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_rf_channel uut (
    .clk(clk), .rst(rst),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cyc_per(input int h, input int l, input int p);
    return (1 << h) * (l + 1) * (p + 1);
  endfunction

  function automatic int cyc_hi(input int h, input int l, input int p,
                                input int r, input int f);
    return (1 << h) * (l + 1) * ((f - r + p + 1) % (p + 1));
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_ctrl(input int h, input int l, input bit pin, input bit od,
                         input bit inv, input bit ce, input bit imm);
    @(negedge clk);
    ctrl_wdata = {imm, ce, inv, od, pin, 4'(h), 8'(l)};
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_duty(input int p, input int r, input int f);
    @(negedge clk);
    duty_wdata = {8'(p), 8'(r), 8'(f)};
    duty_we = 1'b1;
    @(negedge clk);
    duty_we = 1'b0;
  endtask

  task automatic measure(output int hi, output int per);
    int n;
    @(negedge clk);
    while (pwm_o !== 1'b0) @(negedge clk);
    while (pwm_o !== 1'b1) @(negedge clk);
    n = 0;
    while (pwm_o === 1'b1) begin @(negedge clk); n++; end
    hi = n;
    while (pwm_o !== 1'b1) begin @(negedge clk); n++; end
    per = n;
  endtask

  // Starts at a rising edge, rewrites the falling point from 8 to 12
  // two cycles later, and returns the high time of that same period.
  task automatic mid_write(output int hi);
    int n;
    @(negedge clk);
    while (pwm_o !== 1'b0) @(negedge clk);
    while (pwm_o !== 1'b1) @(negedge clk);
    n = 0;
    while (pwm_o === 1'b1) begin
      duty_we    = (n == 2);
      duty_wdata = {8'd15, 8'd0, 8'd12};
      @(negedge clk);
      n++;
    end
    duty_we = 1'b0;
    hi = n;
  endtask

  initial begin
    int hi, per, bad, h, l, p, r, f;
    bit v;
    void'($urandom(32'd20210503));
    do_reset();

    // R1: reset state at the pins
    @(negedge clk);
    chk(pwm_o === 1'b0, "R1 pwm_o after reset", int'(pwm_o), 0);
    chk(pwm_oe === 1'b1, "R1 pwm_oe after reset", int'(pwm_oe), 1);

    // R2 / R3: random dividers, periods and compare points
    for (int i = 0; i < 6; i++) begin
      h = $urandom % 3;
      l = $urandom % 6;
      p = 4 + $urandom % 20;
      r = $urandom % (p + 1);
      f = $urandom % (p + 1);
      if (i == 0) begin r = p - 1; f = 2; end   // high phase spans the wrap
      if (f == r) f = (r + 1) % (p + 1);
      do_reset();
      wr_duty(p, r, f);
      wr_ctrl(h, l, 1, 0, 0, 1, 0);
      measure(hi, per);
      measure(hi, per);
      chk(per == cyc_per(h, l, p), "R2 period length", per, cyc_per(h, l, p));
      chk(hi == cyc_hi(h, l, p, r, f), "R3 high length", hi, cyc_hi(h, l, p, r, f));
    end

    // R4: equal compare points hold the output high
    do_reset();
    wr_duty(9, 3, 3);
    wr_ctrl(0, 0, 1, 0, 0, 1, 0);
    repeat (20) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_o !== 1'b1) bad++; end
    chk(bad == 0, "R4 full duty low cycles", bad, 0);

    // R5: pin disabled forces low and keeps driving
    wr_ctrl(0, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_o !== 1'b0) bad++; end
    chk(bad == 0, "R5 high cycles with pin off", bad, 0);
    chk(pwm_oe === 1'b1, "R5 pwm_oe with pin off", int'(pwm_oe), 1);

    // R8: open drain releases when high, pulls low when pin is off
    wr_ctrl(0, 0, 1, 1, 0, 1, 0);
    repeat (2) @(negedge clk);
    chk(pwm_o === 1'b0 && pwm_oe === 1'b0, "R8 od level high oe", int'(pwm_oe), 0);
    wr_ctrl(0, 0, 0, 1, 0, 1, 0);
    repeat (2) @(negedge clk);
    chk(pwm_o === 1'b0 && pwm_oe === 1'b1, "R8 od pin off oe", int'(pwm_oe), 1);

    // R7: invert takes effect at once and keeps the period
    wr_ctrl(0, 0, 1, 0, 0, 1, 0);
    @(negedge clk);
    wr_ctrl(0, 0, 1, 0, 1, 1, 0);
    @(negedge clk);
    chk(pwm_o === 1'b0, "R7 inverted level", int'(pwm_o), 0);
    wr_duty(15, 0, 8);
    measure(hi, per);
    measure(hi, per);
    chk(per == 16 && hi == 8, "R7 period under invert", per, 16);

    // R6: clock gate freezes, re-enable resumes
    wr_ctrl(0, 0, 1, 0, 0, 1, 0);
    measure(hi, per);
    repeat ($urandom % 7) @(negedge clk);
    wr_ctrl(0, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    v = pwm_o;
    bad = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (pwm_o !== v) bad++; end
    chk(bad == 0, "R6 changes while gated", bad, 0);
    wr_ctrl(0, 0, 1, 0, 0, 1, 0);
    measure(hi, per);
    chk(per == 16, "R6 period after resume", per, 16);

    // R9: shadowed write leaves the current period alone
    do_reset();
    wr_duty(15, 0, 8);
    wr_ctrl(0, 0, 1, 0, 0, 1, 0);
    measure(hi, per);
    mid_write(hi);
    chk(hi == 8, "R9 high in write period", hi, 8);
    measure(hi, per);
    chk(hi == 12, "R9 high after wrap", hi, 12);

    // R10: immediate mode applies inside the current period
    do_reset();
    wr_ctrl(0, 0, 1, 0, 0, 1, 1);
    wr_duty(15, 0, 8);
    measure(hi, per);
    mid_write(hi);
    chk(hi == 12, "R10 high in write period", hi, 12);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule